// File: doc/BRIEF.md
# Eight-Source Vectored Interrupt Controller

This block gathers interrupt requests from eight sources and drives a single group interrupt line to a host processor. Each source's request is latched and can be masked. Acknowledged sources are tracked in an in-service register, and a per-source auto-clear mask decides whether an acknowledge marks the source as in service or releases it. The host line is gated by an enable bit held in a separate control register.

During an acknowledge cycle the controller picks the lowest-numbered unmasked pending source. It returns that source's programmable 8-bit vector plus a fixed bus base offset. Software sees four byte-wide locations: a data window, a command/status location, a control location and a mode readback. Commands written to the command location decide which internal register the next data-window writes land in. Vector-table loads step through the table automatically.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the request, mask, in-service and auto-clear registers are 0, the mode register (readback at address 3) is 0x80, the command/status read (address 1) gives 0x48, the interrupt line is low, and an acknowledge with nothing pending returns 0.
- R2: A source is pending only when its request bit is set and its mask bit is clear; a masked request raises neither the group bit nor the line.
- R3: A read at address 0 returns the in-service, mask, request or auto-clear register when mode bits 6:5 equal 0, 1, 2 or 3 respectively; reads return data one cycle after the read strobe.
- R4: The command/status read carries the source index in bits 2:0, a copy of mode bit 7 in bit 3, mode bit 2 in bit 4, mode bit 0 in bit 5, a constant 1 in bit 6 and the group-pending flag in bit 7.
- R5: Group-pending is 1 only when mode bit 7 is set and at least one source is pending; the index field then holds the highest-numbered pending source, otherwise 0.
- R6: The interrupt line is high exactly when control bit 6 (written at address 2) is set and group-pending is 1.
- R7: An acknowledge completes one cycle later. It takes the lowest-numbered pending source and clears its request bit. If that source's auto-clear bit is set it clears its in-service bit, otherwise it sets it. It returns the stored vector plus the base offset; with nothing pending it returns 0.
- R8: Command code 4 (write data bits 7:5 = 100) points vector loading at entry bits 2:0; each later address-0 write stores one vector and advances the pointer modulo 8.
- R9: A source clear pulse removes the source's request and in-service bits; a set pulse sets its request bit; when both arrive together the clear wins.
- R10: Command bits 7:5 = 000 return request, mask, in-service and auto-clear to 0, the mode to 0x80 and the write target to the mask; codes 1, 2 and 3 aim address-0 writes at the mask, auto-clear and mode registers; codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Location: 0 data, 1 command/status, 2 control, 3 mode readback |
| regWrData | input | 8 | Write data |
| regRdValid | output | 1 | Read data valid, one cycle after the read strobe |
| regRdData | output | 8 | Read data |
| srcSet | input | 8 | Per-source request set pulses |
| srcClr | input | 8 | Per-source request clear pulses |
| ackReq | input | 1 | Interrupt acknowledge request |
| ackDone | output | 1 | Acknowledge result valid |
| ackVector | output | VEC_OUT_W | Returned vector (stored vector plus base), or 0 |
| irqOut | output | 1 | Group interrupt line to the host |

## Verification
The bench goes after the arbitration split. The status index reports the highest pending source while an acknowledge serves the lowest, so a design using one encoder for both would return the wrong vector when sources 1 and 3 are both pending. It also checks the auto-clear split, where an inverted mask test would leave the in-service register at 0x02 instead of 0x08. Other targets are a set and clear arriving together, where a design giving the set priority would leave a stray request bit, and the vector pointer wrap, where a missing modulo would fail to overwrite entry 0. Masked requests, the master-mask bit, the enable gate and an invalid command code are each checked at the ports, along with the reset command restoring every register.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int SRC_N = 8;
  localparam int IDX_W = $clog2(SRC_N);
  localparam int BYTE_W = 8;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CMD  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_MODE = 2'd3;

  localparam logic [BYTE_W-1:0] MODE_RESET = 8'h80;

  localparam int MODE_PRIO_BIT = 0;
  localparam int MODE_INTM_BIT = 2;
  localparam int MODE_MM_BIT   = 7;
  localparam int CTRL_IE_BIT   = 6;

  typedef enum logic [1:0] {
    TGT_IMR  = 2'd0,
    TGT_ACR  = 2'd1,
    TGT_MODE = 2'd2,
    TGT_VEC  = 2'd3
  } vicTarget_t;

  typedef struct packed {
    logic              softRst;
    logic              imrWr;
    logic              acrWr;
    logic              modeWr;
    logic              vecWr;
    logic              ctrlWr;
    logic [IDX_W-1:0]  vecPtr;
    logic [BYTE_W-1:0] wrByte;
  } vicStrobe_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wrData,
  output vicStrobe_t        stb
);
  localparam int OPC_W = 3;

  vicTarget_t       target;
  logic [IDX_W-1:0] vecPtr;
  logic [OPC_W-1:0] opcode;

  assign opcode = wrData[BYTE_W-1 -: OPC_W];

  always_comb begin
    stb        = '0;
    stb.wrByte = wrData;
    stb.vecPtr = vecPtr;
    if (wrEn) begin
      unique case (addr)
        ADDR_DATA: begin
          unique case (target)
            TGT_IMR:  stb.imrWr  = 1'b1;
            TGT_ACR:  stb.acrWr  = 1'b1;
            TGT_MODE: stb.modeWr = 1'b1;
            TGT_VEC:  stb.vecWr  = 1'b1;
            default:  ;
          endcase
        end
        ADDR_CMD:  stb.softRst = (opcode == 3'd0);
        ADDR_CTRL: stb.ctrlWr  = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      target <= TGT_IMR;
      vecPtr <= '0;
    end else if (wrEn && addr == ADDR_CMD) begin
      case (opcode)
        3'd0: begin target <= TGT_IMR; vecPtr <= '0; end
        3'd1: target <= TGT_IMR;
        3'd2: target <= TGT_ACR;
        3'd3: target <= TGT_MODE;
        3'd4: begin target <= TGT_VEC; vecPtr <= wrData[IDX_W-1:0]; end
        default: ;
      endcase
    end else if (stb.vecWr) begin
      vecPtr <= vecPtr + 1'b1;
    end
  end

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.vecWr |=> vecPtr == $past(vecPtr) + 1'b1);

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.imrWr, stb.acrWr, stb.modeWr, stb.vecWr, stb.softRst, stb.ctrlWr}));
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int                   VEC_OUT_W = 9,
  parameter logic [VEC_OUT_W-1:0] VEC_BASE  = VEC_OUT_W'(256)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vicStrobe_t           stb,
  input  logic [SRC_N-1:0]     srcSet,
  input  logic [SRC_N-1:0]     srcClr,
  input  logic                 ackReq,
  input  logic                 rdEn,
  input  logic [1:0]           rdAddr,
  output logic                 rdValid,
  output logic [BYTE_W-1:0]    rdData,
  output logic                 ackDone,
  output logic [VEC_OUT_W-1:0] ackVector,
  output logic                 irqOut
);
  logic [SRC_N-1:0]  irr, imr, isr, acr;
  logic [BYTE_W-1:0] mode;
  logic              ctrlIe;
  logic [BYTE_W-1:0] vecTab [SRC_N];

  logic [SRC_N-1:0]  pending;
  logic              grpPend;
  logic [IDX_W-1:0]  hiIdx, loIdx;
  logic              ackHit;
  logic [SRC_N-1:0]  ackMask;
  logic [SRC_N-1:0]  irrNext, isrNext;
  logic [BYTE_W-1:0] statusByte, dataByte, readByte;

  assign pending = irr & ~imr;
  assign grpPend = mode[MODE_MM_BIT] & (|pending);

  always_comb begin
    hiIdx = '0;
    for (int i = 0; i < SRC_N; i++)
      if (pending[i]) hiIdx = IDX_W'(i);
  end

  always_comb begin
    loIdx = '0;
    for (int i = SRC_N - 1; i >= 0; i--)
      if (pending[i]) loIdx = IDX_W'(i);
  end

  assign ackHit  = ackReq & (|pending);
  assign ackMask = ackHit ? (SRC_N'(1) << loIdx) : '0;

  always_comb begin
    irrNext = ((irr | srcSet) & ~ackMask) & ~srcClr;
    isrNext = isr;
    if (ackHit) begin
      if (acr[loIdx]) isrNext = isr & ~ackMask;
      else            isrNext = isr | ackMask;
    end
    isrNext = isrNext & ~srcClr;
  end

  always_comb begin
    statusByte              = '0;
    statusByte[IDX_W-1:0]   = grpPend ? hiIdx : '0;
    statusByte[3]           = mode[MODE_MM_BIT];
    statusByte[4]           = mode[MODE_INTM_BIT];
    statusByte[5]           = mode[MODE_PRIO_BIT];
    statusByte[6]           = 1'b1;
    statusByte[7]           = grpPend;
  end

  always_comb begin
    unique case (mode[6:5])
      2'd0:    dataByte = isr;
      2'd1:    dataByte = imr;
      2'd2:    dataByte = irr;
      default: dataByte = acr;
    endcase
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_DATA: readByte = dataByte;
      ADDR_CMD:  readByte = statusByte;
      ADDR_CTRL: readByte = BYTE_W'(ctrlIe) << CTRL_IE_BIT;
      default:   readByte = mode;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.softRst) begin
      irr  <= '0;
      imr  <= '0;
      isr  <= '0;
      acr  <= '0;
      mode <= MODE_RESET;
    end else begin
      irr <= irrNext;
      isr <= isrNext;
      if (stb.imrWr)  imr  <= stb.wrByte;
      if (stb.acrWr)  acr  <= stb.wrByte;
      if (stb.modeWr) mode <= stb.wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlIe <= 1'b0;
      for (int k = 0; k < SRC_N; k++) vecTab[k] <= '0;
    end else begin
      if (stb.ctrlWr) ctrlIe <= stb.wrByte[CTRL_IE_BIT];
      if (stb.vecWr)  vecTab[stb.vecPtr] <= stb.wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid   <= 1'b0;
      rdData    <= '0;
      ackDone   <= 1'b0;
      ackVector <= '0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= readByte;
      ackDone <= ackReq;
      if (ackReq)
        ackVector <= ackHit ? (VEC_OUT_W'(vecTab[loIdx]) + VEC_BASE) : '0;
    end
  end

  assign irqOut = ctrlIe & grpPend;

  assert_ack_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> ackDone);

  assert_ack_vector_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && (irr & ~imr) != '0) |=> ackVector >= VEC_BASE);

  assert_line_needs_mm_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (mode[MODE_MM_BIT] && (irr & ~imr) != '0));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    srcClr != '0 |=> ((irr | isr) & $past(srcClr)) == '0);

  assert_set_lands_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((srcSet & ~srcClr) != '0 && !ackReq && !stb.softRst)
      |=> (irr & $past(srcSet & ~srcClr)) == $past(srcSet & ~srcClr));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int                   VEC_OUT_W = 9,
  parameter logic [VEC_OUT_W-1:0] VEC_BASE  = VEC_OUT_W'(256)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [1:0]           regAddr,
  input  logic [7:0]           regWrData,
  output logic                 regRdValid,
  output logic [7:0]           regRdData,
  input  logic [7:0]           srcSet,
  input  logic [7:0]           srcClr,
  input  logic                 ackReq,
  output logic                 ackDone,
  output logic [VEC_OUT_W-1:0] ackVector,
  output logic                 irqOut
);
  vicStrobe_t stb;

  vic_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (regWrEn),
    .addr   (regAddr),
    .wrData (regWrData),
    .stb    (stb)
  );

  vic_datapath #(
    .VEC_OUT_W (VEC_OUT_W),
    .VEC_BASE  (VEC_BASE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .srcSet    (srcSet),
    .srcClr    (srcClr),
    .ackReq    (ackReq),
    .rdEn      (regRdEn),
    .rdAddr    (regAddr),
    .rdValid   (regRdValid),
    .rdData    (regRdData),
    .ackDone   (ackDone),
    .ackVector (ackVector),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
  localparam int VW = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]    regAddr = '0;
  logic [7:0]    regWrData = '0;
  logic          regRdValid;
  logic [7:0]    regRdData;
  logic [7:0]    srcSet = '0, srcClr = '0;
  logic          ackReq = 1'b0;
  logic          ackDone;
  logic [VW-1:0] ackVector;
  logic          irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    bit            isAck;
    logic [VW-1:0] exp;
    string         tag;
  } item_t;
  item_t expQ[$];

  always #4 clk = ~clk;

  irq_vector_ctrl #(.VEC_OUT_W(VW), .VEC_BASE(VW'(256))) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdValid(regRdValid),
    .regRdData(regRdData), .srcSet(srcSet), .srcClr(srcClr),
    .ackReq(ackReq), .ackDone(ackDone), .ackVector(ackVector), .irqOut(irqOut)
  );

  // monitor: pops one expected item per produced result
  always @(negedge clk) begin
    if (rstN && (regRdValid || ackDone)) begin
      item_t it;
      logic [VW-1:0] act;
      act = ackDone ? ackVector : VW'(regRdData);
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected result act=0x%0h exp=none", "R3", act);
      end else begin
        it = expQ.pop_front();
        if (it.isAck != ackDone || act !== it.exp) begin
          fails++;
          $display("FAIL %s: act=0x%0h exp=0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.isAck = 0; it.exp = VW'(e); it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic doAck(input logic [VW-1:0] e, input string tag);
    item_t it;
    it.isAck = 1; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    ackReq = 1'b1;
    @(negedge clk);
    ackReq = 1'b0;
  endtask

  task automatic pulseSrc(input logic [7:0] s, input logic [7:0] c);
    @(negedge clk);
    srcSet = s; srcClr = c;
    @(negedge clk);
    srcSet = '0; srcClr = '0;
  endtask

  task automatic checkIrq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irqOut !== e) begin
      fails++;
      $display("FAIL %s: irqOut act=%0b exp=%0b", tag, irqOut, e);
    end
  endtask

  task automatic setMode(input logic [7:0] m);
    regWrite(2'd1, 8'h60);
    regWrite(2'd0, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(2'd1, 8'h48, "R1");
    regRead(2'd0, 8'h00, "R1");
    regRead(2'd3, 8'h80, "R1");
    checkIrq(1'b0, "R1");
    doAck('0, "R1");

    // R8 vector load with wrap: entry 0 overwritten by the ninth write
    regWrite(2'd1, 8'h80);
    for (int k = 0; k < 8; k++) regWrite(2'd0, 8'h10 + 8'(k));
    regWrite(2'd0, 8'h20);

    // R10 targets: mask src2, auto-clear src1, mode 0xC0
    regWrite(2'd1, 8'h20); regWrite(2'd0, 8'h04);
    regWrite(2'd1, 8'h40); regWrite(2'd0, 8'h02);
    setMode(8'hC0);
    regWrite(2'd2, 8'h40);

    // R2 masked request
    pulseSrc(8'h04, 8'h00);
    checkIrq(1'b0, "R2");
    regRead(2'd1, 8'h48, "R2");
    regRead(2'd0, 8'h04, "R3");

    // R5 highest index, R4 encoding, R6 line
    pulseSrc(8'h0A, 8'h00);
    regRead(2'd1, 8'hCB, "R5");
    checkIrq(1'b1, "R6");
    regWrite(2'd2, 8'h00);
    checkIrq(1'b0, "R6");
    regWrite(2'd2, 8'h40);
    checkIrq(1'b1, "R6");

    // R4/R5: master mask off plus mode copies
    regWrite(2'd0, 8'h45);
    checkIrq(1'b0, "R5");
    regRead(2'd1, 8'h70, "R4");
    regWrite(2'd0, 8'h20);
    regRead(2'd0, 8'h04, "R3");
    regWrite(2'd0, 8'h80);
    regRead(2'd0, 8'h00, "R3");

    // R7 acknowledge: lowest first, auto-clear split
    doAck(VW'(9'h111), "R7");
    regRead(2'd0, 8'h00, "R7");
    doAck(VW'(9'h113), "R7");
    regRead(2'd0, 8'h08, "R7");
    regWrite(2'd0, 8'hC0);
    regRead(2'd0, 8'h04, "R7");
    doAck('0, "R7");
    checkIrq(1'b0, "R7");

    // R9 clear removes in-service; clear wins over set
    pulseSrc(8'h00, 8'h08);
    regWrite(2'd0, 8'h80);
    regRead(2'd0, 8'h00, "R9");
    pulseSrc(8'h01, 8'h01);
    regWrite(2'd0, 8'hC0);
    regRead(2'd0, 8'h04, "R9");
    pulseSrc(8'h01, 8'h00);
    regRead(2'd1, 8'hC8, "R9");
    regWrite(2'd0, 8'hE0);
    regRead(2'd0, 8'h02, "R3");
    doAck(VW'(9'h120), "R8");

    // R10 soft reset and ignored opcode
    regWrite(2'd1, 8'h00);
    regRead(2'd3, 8'h80, "R10");
    regRead(2'd1, 8'h48, "R10");
    regRead(2'd0, 8'h00, "R10");
    checkIrq(1'b0, "R10");
    regWrite(2'd1, 8'hE0);
    regWrite(2'd0, 8'h55);
    setMode(8'hA0);
    regRead(2'd0, 8'h55, "R10");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R3: results missing act=%0d exp=0", expQ.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule